// File: doc/BRIEF.md
# Shadow-Sampling Timing Error Register

This block is a pipeline register for a path that may be clocked faster than its worst-case delay. The data input is captured twice. The main flop samples it on the normal clock edge. A shadow flop samples the same input on a second clock, which is a delayed copy of the main clock and arrives on its own pin. If a slow path was not exercised, both samples agree and the register behaves like an ordinary flop with one cycle of latency. If the data settled after the main edge but before the delayed edge, the two samples disagree. The block then flags a timing error, overwrites its output with the shadow sample and asks the upstream stage to replay.

The two samples are compared at the main edge that follows both captures. On a detected error, the register loads the shadow value at that edge and keeps it through the next edge. It resumes loading the data input at the second edge after detection. The data presented at those two edges is discarded, and the upstream stage uses the one-cycle replay request to resend it. Comparison is suppressed while recovery is under way.

The delayed clock is not generated here, and the clock frequency is not controlled here. The delay between the two clocks must be shorter than the shortest data path into the register; otherwise the next item can overwrite the shadow sample. In simulation, a skewed clock driven by the bench stands in for the analog delay.

Top module: `shadow_timing_reg`

## Requirements
- R1: With no late transitions, `q_out` equals the `d_in` value present at the previous rising edge of `clk`.
- R2: When the `clk` sample and the `clk_shadow` sample of the same item differ, `err_o` is high for exactly the one `clk` cycle that follows the next rising `clk` edge.
- R3: While `err_o` is high, `q_out` holds the shadow sample of the failing item, not the main sample.
- R4: `replay_o` is high in exactly the cycles in which `err_o` is high, for one cycle per error.
- R5: The edge at which an error is detected and the edge after it do not load `d_in`. `q_out` keeps the corrected value across that second edge, and `d_in` is loaded again from the second edge after detection.
- R6: `err_o` is never high in two consecutive cycles. A disagreement on data presented at the two edges that follow detection does not raise `err_o`.
- R7: A low `rst_n` at a rising `clk` edge clears `q_out`, `err_o` and `replay_o`. A low `rst_n` at a rising `clk_shadow` edge clears the shadow sample, so no error follows reset release.
- R8: A late transition on any single bit position, from bit 0 to bit DATA_W-1, is detected.
- R9: After recovery, a new late transition is detected normally. The earliest second error is three cycles after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main sampling clock |
| clk_shadow | input | 1 | Delayed copy of `clk` that clocks the shadow flop |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| d_in | input | DATA_W | Data from the upstream logic path |
| q_out | output | DATA_W | Registered (and, after an error, corrected) data |
| err_o | output | 1 | Timing-error flag, high for one cycle per detection |
| replay_o | output | 1 | One-cycle request to the upstream stage to resend |

## Verification
The assertions check the following on every cycle:
- `err_o` and `replay_o` each last one cycle and coincide.
- At least two quiet cycles follow every error.
- `q_out` is held across the cycle after an error.
- All outputs are zero after a reset edge.

Some behaviour only the bench's scenarios can show:
- The corrected output equals the shadow sample rather than the stale main sample.
- Every bit position can raise the flag.
- Disagreements during recovery are masked.
- A fresh error is caught right after recovery.

The bench creates these conditions by driving a stale value before the main edge and the correct value between the two edges.

// File: rtl/tsr_pkg.sv
// Shared types for the shadow-sampling timing error register.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package tsr_pkg;

    // Recovery phase, recording what the main flop did at the last clk edge.
    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,   // loaded d_in; main and shadow samples are comparable
        PH_FIX  = 2'd1,   // loaded the shadow sample after a detected error
        PH_HOLD = 2'd2    // kept the corrected value for one more cycle
    } phase_e;

    // Source selected for the main flop at the next clk edge.
    typedef enum logic [1:0] {
        SRC_DATA   = 2'd0,
        SRC_SHADOW = 2'd1,
        SRC_KEEP   = 2'd2
    } src_e;

endpackage

// File: rtl/tsr_shadow_stage.sv
// Shadow flop: samples d_in on the delayed clock.
// Assumes clk_shadow trails clk by less than the shortest data path delay,
// so the value held here belongs to the item the main flop captured last.
module tsr_shadow_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk_shadow,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] shadow_q
);

    // Late sample of the data, cleared by a synchronous reset on its own clock.
    always_ff @(posedge clk_shadow) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else begin
            shadow_q <= d_in;
        end
    end

endmodule

// File: rtl/tsr_mismatch.sv
// Bitwise comparison of the main and shadow samples, gated by an enable.
// Assumes both operands are stable at the clk edge that uses the result.
module tsr_mismatch #(
    parameter int DATA_W = 16
) (
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] main_q,
    input  logic [DATA_W-1:0] shadow_q,
    output logic              mismatch
);

    logic [DATA_W-1:0] diff_bits;

    // One difference bit for each data lane.
    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        assign diff_bits[b] = main_q[b] ^ shadow_q[b];
    end

    // Raise the flag only while a comparison is meaningful.
    always_comb begin
        mismatch = cmp_en && (|diff_bits);
    end

endmodule

// File: rtl/tsr_main_stage.sv
// Main flop: loads d_in, loads the shadow sample, or keeps its value.
// Assumes src_sel is settled before the clk edge.
module tsr_main_stage
    import tsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_e              src_sel,
    input  logic [DATA_W-1:0] d_in,
    input  logic [DATA_W-1:0] shadow_q,
    output logic [DATA_W-1:0] main_q
);

    // Register update with a synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q <= '0;
        end else begin
            case (src_sel)
                SRC_DATA:   main_q <= d_in;
                SRC_SHADOW: main_q <= shadow_q;
                default:    main_q <= main_q;
            endcase
        end
    end

endmodule

// File: rtl/tsr_recovery_ctrl.sv
// Recovery sequencer: detects errors, selects the main flop source, and
// drives the one-cycle error flag and replay request.
// Assumes mismatch is already gated by cmp_en.
module tsr_recovery_ctrl
    import tsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch,
    output logic cmp_en,
    output src_e src_sel,
    output logic err_o,
    output logic replay_o
);

    phase_e phase_q;
    phase_e phase_d;

    // Comparison is valid only after an ordinary load of d_in.
    always_comb begin
        cmp_en = (phase_q == PH_RUN);
    end

    // Next phase and main flop source, from the current phase and the compare result.
    always_comb begin
        phase_d = PH_RUN;
        src_sel = SRC_DATA;
        case (phase_q)
            PH_RUN: begin
                if (mismatch) begin
                    phase_d = PH_FIX;
                    src_sel = SRC_SHADOW;
                end
            end
            PH_FIX: begin
                phase_d = PH_HOLD;
                src_sel = SRC_KEEP;
            end
            default: begin
                phase_d = PH_RUN;
                src_sel = SRC_DATA;
            end
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RUN;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Error flag: set only on a detection edge, so it lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else begin
            err_o <= (phase_q == PH_RUN) && mismatch;
        end
    end

    // Replay request to the upstream stage, issued with the error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            replay_o <= 1'b0;
        end else begin
            replay_o <= (src_sel == SRC_SHADOW);
        end
    end

endmodule

// File: rtl/shadow_timing_reg.sv
// Top level of the shadow-sampling timing error register.
// Captures d_in on clk and on clk_shadow, compares the two samples at the
// next clk edge, and corrects the output and requests a replay on disagreement.
// Assumes the clk to clk_shadow skew is shorter than the minimum data path delay.
module shadow_timing_reg
    import tsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              clk_shadow,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] q_out,
    output logic              err_o,
    output logic              replay_o
);

    logic [DATA_W-1:0] main_q;
    logic [DATA_W-1:0] shadow_q;
    logic              mismatch;
    logic              cmp_en;
    src_e              src_sel;

    tsr_shadow_stage #(.DATA_W(DATA_W)) u_shadow (
        .clk_shadow (clk_shadow),
        .rst_n      (rst_n),
        .d_in       (d_in),
        .shadow_q   (shadow_q)
    );

    tsr_mismatch #(.DATA_W(DATA_W)) u_cmp (
        .cmp_en   (cmp_en),
        .main_q   (main_q),
        .shadow_q (shadow_q),
        .mismatch (mismatch)
    );

    tsr_recovery_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mismatch (mismatch),
        .cmp_en   (cmp_en),
        .src_sel  (src_sel),
        .err_o    (err_o),
        .replay_o (replay_o)
    );

    tsr_main_stage #(.DATA_W(DATA_W)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .d_in     (d_in),
        .shadow_q (shadow_q),
        .main_q   (main_q)
    );

    // The main flop drives the output directly.
    assign q_out = main_q;

endmodule

// File: rtl/shadow_timing_reg_chk.sv
// Checker for shadow_timing_reg: port-level temporal properties, bound to the top.
module shadow_timing_reg_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] q_out,
    input logic              err_o,
    input logic              replay_o
);

    logic rst_seen_q;

    // Remember whether the previous clk edge saw reset asserted.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R7: after a reset edge all outputs read zero.
    always_ff @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            p_reset_clear_r7: assert (q_out == '0 && !err_o && !replay_o)
                else $error("p_reset_clear_r7 violated");
        end
    end

    // R2: the error flag lasts exactly one cycle.
    p_err_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R4: the replay request accompanies every error cycle.
    p_replay_with_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> replay_o);

    // R4: no replay request without an error.
    p_replay_only_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        replay_o |-> err_o);

    // R5: the corrected value is held across the edge after the error.
    p_hold_fix_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> $stable(q_out));

    // R6: two quiet cycles follow every error.
    p_err_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o ##1 !err_o);

endmodule

bind shadow_timing_reg shadow_timing_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_out    (q_out),
    .err_o    (err_o),
    .replay_o (replay_o)
);

// File: tb/shadow_timing_reg_tb.sv
`timescale 1ns/1ps
// Bench for shadow_timing_reg. The delayed clock trails clk by 2 ns. Each item
// is driven 5 ns after a clk edge; a late item shows a stale value until 1 ns
// after its capturing edge, which falls between the main and delayed edges.
module shadow_timing_reg_tb;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          clk_shadow = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] d_in = '0;
    logic [DW-1:0] q_out;
    logic          err_o;
    logic          replay_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state, derived from the requirements.
    logic [DW-1:0] m_q = '0;
    logic [DW-1:0] m_sh = '0;
    logic          m_err = 1'b0;
    int            m_ph = 0;   // 0 running, 1 just corrected, 2 holding

    shadow_timing_reg #(.DATA_W(DW)) u_dut (
        .clk        (clk),
        .clk_shadow (clk_shadow),
        .rst_n      (rst_n),
        .d_in       (d_in),
        .q_out      (q_out),
        .err_o      (err_o),
        .replay_o   (replay_o)
    );

    // 125 MHz main clock, with the shadow clock 2 ns behind it.
    initial begin
        forever begin
            clk = 1'b1;
            #2 clk_shadow = 1'b1;
            #2 clk = 1'b0;
            #2 clk_shadow = 1'b0;
            #2;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected main-edge update (R1, R3, R5, R7).
    function automatic logic [DW-1:0] exp_q(input bit rstv, input logic [DW-1:0] ms);
        if (!rstv) return '0;
        if (m_ph == 0) return (m_q != m_sh) ? m_sh : ms;
        if (m_ph == 1) return m_q;
        return ms;
    endfunction

    // Expected error flag after a main edge (R2, R6).
    function automatic logic exp_err(input bit rstv);
        return rstv && (m_ph == 0) && (m_q != m_sh);
    endfunction

    // Advance the reference model by one main edge.
    task automatic model_edge(input bit rstv, input logic [DW-1:0] ms);
        logic [DW-1:0] nq;
        logic          ne;
        int            np;
        nq = exp_q(rstv, ms);
        ne = exp_err(rstv);
        if (!rstv)          np = 0;
        else if (ne)        np = 1;
        else if (m_ph == 1) np = 2;
        else                np = 0;
        m_q = nq;
        m_err = ne;
        m_ph = np;
    endtask

    // One item: drive, capture, check, and return at 5 ns after the edge.
    task automatic step(input logic [DW-1:0] v, input bit late,
                        input logic [DW-1:0] x, input bit rstv);
        string tq;
        rst_n = rstv;
        d_in = late ? (v ^ x) : v;
        @(posedge clk);
        model_edge(rstv, late ? (v ^ x) : v);
        #1;
        if (late) d_in = v;
        m_sh = rstv ? v : '0;
        #3;
        if (!rstv)          tq = "R7";
        else if (m_err)     tq = "R3";
        else if (m_ph == 2) tq = "R5";
        else                tq = "R1";
        check(q_out === m_q, tq, "q_out", 32'(q_out), 32'(m_q));
        check(err_o === m_err, rstv ? "R2" : "R7", "err_o", 32'(err_o), 32'(m_err));
        check(replay_o === m_err, "R4", "replay_o", 32'(replay_o), 32'(m_err));
        #1;
    endtask

    initial begin
        logic [DW-1:0] a;
        logic [DW-1:0] x;
        void'($urandom(32'd20240611));

        // Reset phase (R7).
        for (int i = 0; i < 3; i++) step('0, 1'b0, '0, 1'b0);
        check(q_out === '0 && !err_o && !replay_o, "R7", "outputs in reset",
              {q_out, 14'd0, err_o, replay_o}, 32'd0);

        // Plain pipelining with no late data (R1).
        for (int i = 0; i < 8; i++) step(DW'($urandom), 1'b0, '0, 1'b1);
        step(16'hA5C3, 1'b0, '0, 1'b1);
        check(q_out === 16'hA5C3, "R1", "one-cycle latency", 32'(q_out), 32'hA5C3);

        // Single late item: error, correction, replay, hold, resume (R2 R3 R4 R5).
        step(16'h1234, 1'b1, 16'h00F0, 1'b1);
        check(q_out === 16'h12C4, "R3", "stale main sample visible", 32'(q_out), 32'h12C4);
        step(16'hBEEF, 1'b0, '0, 1'b1);
        check(err_o === 1'b1, "R2", "error raised", 32'(err_o), 32'd1);
        check(q_out === 16'h1234, "R3", "corrected to shadow", 32'(q_out), 32'h1234);
        check(replay_o === 1'b1, "R4", "replay raised", 32'(replay_o), 32'd1);
        step(16'h5555, 1'b1, 16'h0101, 1'b1);
        check(q_out === 16'h1234 && err_o === 1'b0, "R5", "hold and no error",
              {q_out, 15'd0, err_o}, {16'h1234, 16'd0});
        step(16'h7777, 1'b1, 16'h8000, 1'b1);
        check(q_out === 16'hF777, "R5", "load resumes", 32'(q_out), 32'hF777);
        check(err_o === 1'b0, "R6", "masked during recovery", 32'(err_o), 32'd0);
        step(16'h0F0F, 1'b0, '0, 1'b1);
        check(err_o === 1'b1 && q_out === 16'h7777, "R9", "error right after recovery",
              {q_out, 15'd0, err_o}, {16'h7777, 16'd1});
        step(16'h0000, 1'b0, '0, 1'b1);
        step(16'h3C3C, 1'b0, '0, 1'b1);
        check(q_out === 16'h3C3C && err_o === 1'b0, "R1", "clean after recovery",
              {q_out, 15'd0, err_o}, {16'h3C3C, 16'd0});

        // Every bit position can raise the flag (R8).
        for (int b = 0; b < DW; b++) begin
            a = DW'($urandom);
            step(a, 1'b1, DW'(1) << b, 1'b1);
            step(DW'($urandom), 1'b0, '0, 1'b1);
            check(err_o === 1'b1 && q_out === a, "R8", $sformatf("bit %0d detected", b),
                  {q_out, 15'd0, err_o}, {a, 16'd1});
            step(DW'($urandom), 1'b0, '0, 1'b1);
            step(DW'($urandom), 1'b0, '0, 1'b1);
        end

        // Reset while correcting (R7).
        step(16'hCAFE, 1'b1, 16'h0003, 1'b1);
        step(16'h1111, 1'b0, '0, 1'b1);
        step(16'h2222, 1'b0, '0, 1'b0);
        check(q_out === '0 && !err_o && !replay_o, "R7", "reset during recovery",
              {q_out, 14'd0, err_o, replay_o}, 32'd0);
        step(16'h4444, 1'b0, '0, 1'b1);
        step(16'h6666, 1'b0, '0, 1'b1);
        check(err_o === 1'b0 && q_out === 16'h6666, "R7", "no error after release",
              {q_out, 15'd0, err_o}, {16'h6666, 16'd0});

        // Random traffic with occasional late items.
        for (int n = 0; n < 400; n++) begin
            x = DW'($urandom);
            if (x == '0) x = 16'h0001;
            step(DW'($urandom), ($urandom % 6) == 0, x, 1'b1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule